// File: doc/BRIEF.md
# Instruction Bus-Cycle Type Sequencer

This block turns one instruction, as it reaches the execute stage, into the run of memory-bus cycle types that the instruction occupies. There is one entry per clock. The four cycle types are non-sequential (N), sequential (S), internal (I) and coprocessor (C). The caller pulses `start` with an instruction class code and its qualifiers. These are a condition-pass flag, a program-counter-destination flag, a register-specified-shift flag, a transfer word count and the multiplier operand. The block then plays out the sequence on `cyc_type` with `cyc_valid` high and pulses `cyc_done` on the final entry.

Two inputs change the length of a sequence while it runs. For multiplies, the number of internal cycles follows how many upper bytes of the operand are pure sign extension. For coprocessor classes, a leading busy-wait emits one I cycle for every clock in which `cp_busy` is high, and the tail of the instruction follows in the first clock with `cp_busy` low. The block models only the timing: it moves no data and drives no memory.

Top module: `bus_cycle_sequencer`

## Requirements
- R1: The block only samples `start` while it is idle (`cyc_valid` low). The first cycle type is presented in the clock after the sampling edge. From then on, `cyc_valid` stays high on every clock up to and including the `cyc_done` clock. With no start, `cyc_valid` stays low. Cycle-type codes are N=0, S=1, I=2, C=3.
- R2: `cyc_done` is high only on the final cycle of a sequence, and `cyc_valid` is low in the clock that follows. A `start` given while a sequence runs is ignored, including a `start` given during the `cyc_done` clock, and leaves that sequence unchanged.
- R3: When `cond_pass` is low, every class produces exactly one S.
- R4: For data processing (class 0), the plain form gives S and the register-shift form (`reg_shift`) gives I,S. With `pc_dest` the plain form gives N,S,S and the register-shift form gives I,N,S,S.
- R5: The multiply count m is 1 if operand bits 31:8 are all zeros or all ones, 2 if bits 31:16 are, 3 if bits 31:24 are, and 4 otherwise.
- R6: MUL (class 1) gives m I then S. MLA (2) gives I, m I, S. Long multiply (3) gives m I, I, S. Long multiply-accumulate (4) gives I, m I, I, S.
- R7: Branch (5) and software interrupt (6) give N,S,S. Status-register move (12), and any class code above 16, give a single S.
- R8: Load (7) gives N,I,S, or N,I,N,S,S with `pc_dest`. Store (8) gives N,N. Swap (9) gives N,N,I,S.
- R9: Load-multiple (10) gives N, (n-1) S, I, then S, or N,S,S with `pc_dest`. Store-multiple (11) gives N, (n-1) S, I, N. With n of 1 or 0, no repeated S is inserted.
- R10: Coprocessor classes first give one I for each clock in which `cp_busy` is high, then their tail. Data op (13) has the tail S. Register write (14) has C,N. Register read (15) has C,I,S. Coprocessor load/store (16) has N, (n-1) S, N.
- R11: A synchronous active-low reset ends any running sequence. While reset is held and in the clock after it, `cyc_valid` and `cyc_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| instr_class | input | 5 | Instruction class code |
| cond_pass | input | 1 | Condition check passed |
| pc_dest | input | 1 | Instruction writes the program counter |
| reg_shift | input | 1 | Data processing uses a register-specified shift |
| word_count | input | WCW (5) | Transfer word count n |
| mul_operand | input | XLEN (32) | Multiplier operand |
| cp_busy | input | 1 | Coprocessor busy, live during busy-wait |
| cyc_type | output | 2 | Current cycle type: N=0, S=1, I=2, C=3 |
| cyc_valid | output | 1 | A cycle of the sequence is presented |
| cyc_done | output | 1 | Final cycle of the sequence |

## Verification
Two functions of this block can meet in one clock. The first is the done pulse of a sequence together with a new `start`. The bench drives `start` high during the `cyc_done` clock and also in the middle of a run. It judges the result by checking that the running sequence keeps its expected content and that `cyc_valid` is low in the clock after the done. The second is the fall of `cp_busy` together with the first tail cycle. It is provoked with busy-waits of 0, 1, 2 and 5 clocks. It is judged by comparing the full emitted sequence, cycle by cycle, against a model written from the requirements.

// File: rtl/bcs_pkg.sv
// Shared types for the bus-cycle sequencer.
// Assumes: cycle-type codes and class codes are fixed by the requirements.
package bcs_pkg;

    typedef enum logic [1:0] {
        CYC_N = 2'd0,
        CYC_S = 2'd1,
        CYC_I = 2'd2,
        CYC_C = 2'd3
    } cyc_e;

    typedef enum logic [4:0] {
        CL_DP     = 5'd0,
        CL_MUL    = 5'd1,
        CL_MLA    = 5'd2,
        CL_MULL   = 5'd3,
        CL_MLAL   = 5'd4,
        CL_BRANCH = 5'd5,
        CL_SWI    = 5'd6,
        CL_LDR    = 5'd7,
        CL_STR    = 5'd8,
        CL_SWP    = 5'd9,
        CL_LDM    = 5'd10,
        CL_STM    = 5'd11,
        CL_PSR    = 5'd12,
        CL_CDP    = 5'd13,
        CL_MCR    = 5'd14,
        CL_MRC    = 5'd15,
        CL_CPLS   = 5'd16
    } iclass_e;

    // Longest program: load-multiple into the program counter (6 phases).
    localparam int NPH = 6;

endpackage

// File: rtl/bcs_mult_len.sv
// Multiplier early-termination length.
// Returns m = smallest k in 1..XLEN/8-1 such that operand bits [XLEN-1:8k]
// are all zeros or all ones, else XLEN/8.
// Assumes: XLEN is a multiple of 8 and at least 16.
module bcs_mult_len #(
    parameter int XLEN = 32,
    parameter int MW   = 3
) (
    input  logic [XLEN-1:0] operand,
    output logic [MW-1:0]   m_len
);
    localparam int NSTG = XLEN / 8 - 1;

    logic [NSTG:1] narrow;

    // One sign-extension detector per byte boundary.
    for (genvar k = 1; k <= NSTG; k++) begin : g_stage
        assign narrow[k] = (&operand[XLEN-1:8*k]) | ~(|operand[XLEN-1:8*k]);
    end

    // Pick the lowest boundary whose upper part is pure sign extension.
    always_comb begin
        m_len = MW'(NSTG + 1);
        for (int k = NSTG; k >= 1; k--) begin
            if (narrow[k]) m_len = MW'(k);
        end
    end

endmodule

// File: rtl/bcs_program_rom.sv
// Translates an instruction class and its qualifiers into a short program of
// phases. Each phase has a cycle type, a repeat count and a busy-wait flag.
// Phases with a zero count are squeezed out, so the walker never has to
// skip them. A busy-wait phase carries count 1 and is only ever first.
module bcs_program_rom
    import bcs_pkg::*;
#(
    parameter int WCW = 5,
    parameter int CW  = 5,
    parameter int IW  = 3
) (
    input  logic [4:0]     cls,
    input  logic           cond_pass,
    input  logic           pc_dest,
    input  logic           reg_shift,
    input  logic [WCW-1:0] n_words,
    input  logic [CW-1:0]  m_len,
    output cyc_e           ph_typ  [NPH],
    output logic           ph_wait [NPH],
    output logic [CW-1:0]  ph_cnt  [NPH],
    output logic [IW-1:0]  ph_num
);
    typedef struct packed {
        cyc_e          typ;
        logic          wait_busy;
        logic [CW-1:0] cnt;
    } phase_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    function automatic phase_t mk(cyc_e t, logic w, logic [CW-1:0] c);
        phase_t p;
        p.typ       = t;
        p.wait_busy = w;
        p.cnt       = c;
        return p;
    endfunction

    phase_t        raw [NPH];
    phase_t        pak [NPH];
    logic [CW-1:0] nm1;
    logic [IW-1:0] k;

    // Repeated-S count for block transfers: n-1, with n of 0 treated as 1.
    always_comb nm1 = (n_words == '0) ? '0 : CW'(n_words) - ONE;

    // Raw phase list for each class.
    always_comb begin
        for (int i = 0; i < NPH; i++) raw[i] = mk(CYC_S, 1'b0, '0);
        if (!cond_pass) begin
            raw[0] = mk(CYC_S, 1'b0, ONE);
        end else begin
            case (cls)
                CL_DP: begin
                    if (reg_shift) raw[0] = mk(CYC_I, 1'b0, ONE);
                    if (pc_dest) begin
                        raw[1] = mk(CYC_N, 1'b0, ONE);
                        raw[2] = mk(CYC_S, 1'b0, ONE);
                        raw[3] = mk(CYC_S, 1'b0, ONE);
                    end else begin
                        raw[1] = mk(CYC_S, 1'b0, ONE);
                    end
                end
                CL_MUL: begin
                    raw[0] = mk(CYC_I, 1'b0, m_len);
                    raw[1] = mk(CYC_S, 1'b0, ONE);
                end
                CL_MLA: begin
                    raw[0] = mk(CYC_I, 1'b0, ONE);
                    raw[1] = mk(CYC_I, 1'b0, m_len);
                    raw[2] = mk(CYC_S, 1'b0, ONE);
                end
                CL_MULL: begin
                    raw[0] = mk(CYC_I, 1'b0, m_len);
                    raw[1] = mk(CYC_I, 1'b0, ONE);
                    raw[2] = mk(CYC_S, 1'b0, ONE);
                end
                CL_MLAL: begin
                    raw[0] = mk(CYC_I, 1'b0, ONE);
                    raw[1] = mk(CYC_I, 1'b0, m_len);
                    raw[2] = mk(CYC_I, 1'b0, ONE);
                    raw[3] = mk(CYC_S, 1'b0, ONE);
                end
                CL_BRANCH, CL_SWI: begin
                    raw[0] = mk(CYC_N, 1'b0, ONE);
                    raw[1] = mk(CYC_S, 1'b0, ONE);
                    raw[2] = mk(CYC_S, 1'b0, ONE);
                end
                CL_LDR: begin
                    raw[0] = mk(CYC_N, 1'b0, ONE);
                    raw[1] = mk(CYC_I, 1'b0, ONE);
                    if (pc_dest) begin
                        raw[2] = mk(CYC_N, 1'b0, ONE);
                        raw[3] = mk(CYC_S, 1'b0, ONE);
                        raw[4] = mk(CYC_S, 1'b0, ONE);
                    end else begin
                        raw[2] = mk(CYC_S, 1'b0, ONE);
                    end
                end
                CL_STR: begin
                    raw[0] = mk(CYC_N, 1'b0, ONE);
                    raw[1] = mk(CYC_N, 1'b0, ONE);
                end
                CL_SWP: begin
                    raw[0] = mk(CYC_N, 1'b0, ONE);
                    raw[1] = mk(CYC_N, 1'b0, ONE);
                    raw[2] = mk(CYC_I, 1'b0, ONE);
                    raw[3] = mk(CYC_S, 1'b0, ONE);
                end
                CL_LDM: begin
                    raw[0] = mk(CYC_N, 1'b0, ONE);
                    raw[1] = mk(CYC_S, 1'b0, nm1);
                    raw[2] = mk(CYC_I, 1'b0, ONE);
                    if (pc_dest) begin
                        raw[3] = mk(CYC_N, 1'b0, ONE);
                        raw[4] = mk(CYC_S, 1'b0, ONE);
                        raw[5] = mk(CYC_S, 1'b0, ONE);
                    end else begin
                        raw[3] = mk(CYC_S, 1'b0, ONE);
                    end
                end
                CL_STM: begin
                    raw[0] = mk(CYC_N, 1'b0, ONE);
                    raw[1] = mk(CYC_S, 1'b0, nm1);
                    raw[2] = mk(CYC_I, 1'b0, ONE);
                    raw[3] = mk(CYC_N, 1'b0, ONE);
                end
                CL_CDP: begin
                    raw[0] = mk(CYC_I, 1'b1, ONE);
                    raw[1] = mk(CYC_S, 1'b0, ONE);
                end
                CL_MCR: begin
                    raw[0] = mk(CYC_I, 1'b1, ONE);
                    raw[1] = mk(CYC_C, 1'b0, ONE);
                    raw[2] = mk(CYC_N, 1'b0, ONE);
                end
                CL_MRC: begin
                    raw[0] = mk(CYC_I, 1'b1, ONE);
                    raw[1] = mk(CYC_C, 1'b0, ONE);
                    raw[2] = mk(CYC_I, 1'b0, ONE);
                    raw[3] = mk(CYC_S, 1'b0, ONE);
                end
                CL_CPLS: begin
                    raw[0] = mk(CYC_I, 1'b1, ONE);
                    raw[1] = mk(CYC_N, 1'b0, ONE);
                    raw[2] = mk(CYC_S, 1'b0, nm1);
                    raw[3] = mk(CYC_N, 1'b0, ONE);
                end
                default: raw[0] = mk(CYC_S, 1'b0, ONE);
            endcase
        end
    end

    // Squeeze out empty phases and count what remains.
    always_comb begin
        for (int i = 0; i < NPH; i++) pak[i] = mk(CYC_S, 1'b0, '0);
        k = '0;
        for (int i = 0; i < NPH; i++) begin
            if (raw[i].cnt != '0) begin
                pak[k] = raw[i];
                k      = k + IW'(1);
            end
        end
        ph_num = k;
    end

    // Unpack into per-field arrays for the walker.
    always_comb begin
        for (int i = 0; i < NPH; i++) begin
            ph_typ[i]  = pak[i].typ;
            ph_wait[i] = pak[i].wait_busy;
            ph_cnt[i]  = pak[i].cnt;
        end
    end

endmodule

// File: rtl/bcs_phase_walker.sv
// Plays a latched phase program out one cycle type per clock.
// A busy-wait phase is held while cp_busy is high. When cp_busy is low, the
// next phase is emitted in the same clock, so a zero-length wait costs nothing.
// Assumes: a busy-wait phase is never the last phase and is never followed by
// another busy-wait phase.
module bcs_phase_walker
    import bcs_pkg::*;
#(
    parameter int CW = 5,
    parameter int IW = 3,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  cyc_e          ph_typ  [NPH],
    input  logic          ph_wait [NPH],
    input  logic [CW-1:0] ph_cnt  [NPH],
    input  logic [IW-1:0] ph_num,
    input  logic          cp_busy,
    output logic          active,
    output cyc_e          typ,
    output logic          done
);
    cyc_e          st_typ  [NPH];
    logic          st_wait [NPH];
    logic [CW-1:0] st_cnt  [NPH];
    logic [IW-1:0] st_num;
    logic [PW-1:0] idx;
    logic [CW-1:0] rem;

    logic          skip;
    logic [PW-1:0] eff;
    logic [PW-1:0] nxt;
    logic [CW-1:0] eff_rem;
    logic          holding;
    logic          last_ph;

    // Pick the phase this clock: jump past a finished busy-wait.
    always_comb begin
        skip    = st_wait[idx] && !cp_busy;
        eff     = idx + {{(PW-1){1'b0}}, skip};
        nxt     = eff + PW'(1);
        eff_rem = skip ? st_cnt[eff] : rem;
        holding = st_wait[eff];
        last_ph = (IW'(eff) + IW'(1)) == st_num;
        done    = active && !holding && (eff_rem == CW'(1)) && last_ph;
        typ     = active ? st_typ[eff] : CYC_N;
    end

    // Latch a new program when idle, then step through it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            rem    <= '0;
            st_num <= '0;
            for (int i = 0; i < NPH; i++) begin
                st_typ[i]  <= CYC_S;
                st_wait[i] <= 1'b0;
                st_cnt[i]  <= '0;
            end
        end else if (!active) begin
            if (load) begin
                active <= 1'b1;
                idx    <= '0;
                rem    <= ph_cnt[0];
                st_num <= ph_num;
                for (int i = 0; i < NPH; i++) begin
                    st_typ[i]  <= ph_typ[i];
                    st_wait[i] <= ph_wait[i];
                    st_cnt[i]  <= ph_cnt[i];
                end
            end
        end else if (holding) begin
            idx <= eff;
        end else if (eff_rem > CW'(1)) begin
            idx <= eff;
            rem <= eff_rem - CW'(1);
        end else if (last_ph) begin
            active <= 1'b0;
        end else begin
            idx <= nxt;
            rem <= st_cnt[nxt];
        end
    end

    // R2: the clock after a done pulse is idle.
    assert_idle_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active);

    // R1: a sequence runs without gaps until its done pulse.
    assert_no_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done) |=> active);

endmodule

// File: rtl/bus_cycle_sequencer.sv
// Top of the bus-cycle type sequencer.
// Takes one instruction class per start pulse while idle, and emits that
// instruction's N/S/I/C cycle types, one per clock, with a done pulse on
// the last one.
// Assumes: XLEN is a multiple of 8; word counts fit in WCW bits.
module bus_cycle_sequencer
    import bcs_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int WCW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [4:0]      instr_class,
    input  logic            cond_pass,
    input  logic            pc_dest,
    input  logic            reg_shift,
    input  logic [WCW-1:0]  word_count,
    input  logic [XLEN-1:0] mul_operand,
    input  logic            cp_busy,
    output logic [1:0]      cyc_type,
    output logic            cyc_valid,
    output logic            cyc_done
);
    localparam int MAXM = XLEN / 8;
    localparam int MBW  = $clog2(MAXM + 1);
    localparam int CW   = (WCW > MBW) ? WCW : MBW;
    localparam int IW   = $clog2(NPH + 1);
    localparam int PW   = $clog2(NPH);

    logic [CW-1:0] m_len;
    cyc_e          ph_typ  [NPH];
    logic          ph_wait [NPH];
    logic [CW-1:0] ph_cnt  [NPH];
    logic [IW-1:0] ph_num;
    cyc_e          w_typ;

    bcs_mult_len #(
        .XLEN (XLEN),
        .MW   (CW)
    ) u_mlen (
        .operand (mul_operand),
        .m_len   (m_len)
    );

    bcs_program_rom #(
        .WCW (WCW),
        .CW  (CW),
        .IW  (IW)
    ) u_rom (
        .cls       (instr_class),
        .cond_pass (cond_pass),
        .pc_dest   (pc_dest),
        .reg_shift (reg_shift),
        .n_words   (word_count),
        .m_len     (m_len),
        .ph_typ    (ph_typ),
        .ph_wait   (ph_wait),
        .ph_cnt    (ph_cnt),
        .ph_num    (ph_num)
    );

    bcs_phase_walker #(
        .CW (CW),
        .IW (IW),
        .PW (PW)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .ph_typ  (ph_typ),
        .ph_wait (ph_wait),
        .ph_cnt  (ph_cnt),
        .ph_num  (ph_num),
        .cp_busy (cp_busy),
        .active  (cyc_valid),
        .typ     (w_typ),
        .done    (cyc_done)
    );

    // Present the walker's cycle type on the plain port.
    always_comb cyc_type = w_typ;

    // R1: a sequence only begins after a start sampled while idle.
    assert_start_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_valid) |-> $past(start));

    // R3: a failed condition yields one S and finishes at once.
    assert_cond_fail_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cyc_valid && !cond_pass) |=> (cyc_done && cyc_type == 2'd1));

    // R5: a zero-extended short operand takes one I before the final S.
    assert_short_mul_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cyc_valid && cond_pass && instr_class == 5'd1
         && mul_operand[XLEN-1:8] == '0)
        |=> (cyc_type == 2'd2 && !cyc_done) ##1 (cyc_type == 2'd1 && cyc_done));

endmodule

// File: tb/bus_cycle_sequencer_tb.sv
module bus_cycle_sequencer_tb;

    localparam logic [1:0] TN = 2'd0;
    localparam logic [1:0] TS = 2'd1;
    localparam logic [1:0] TI = 2'd2;
    localparam logic [1:0] TC = 2'd3;

    typedef struct packed {
        logic [4:0]  cls;
        logic        cond;
        logic        pc;
        logic        sh;
        logic [4:0]  n;
        logic [31:0] op;
        logic [3:0]  busy;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd0}, // R4 plain
        '{5'd0,  1'b1, 1'b0, 1'b1, 5'd1,  32'h0,        4'd0}, // R4 shift
        '{5'd0,  1'b1, 1'b1, 1'b0, 5'd1,  32'h0,        4'd0}, // R4 pc
        '{5'd0,  1'b1, 1'b1, 1'b1, 5'd1,  32'h0,        4'd0}, // R4 pc+shift
        '{5'd1,  1'b1, 1'b0, 1'b0, 5'd1,  32'h00000012, 4'd0}, // R5 m=1
        '{5'd2,  1'b1, 1'b0, 1'b0, 5'd1,  32'hFFFF8000, 4'd0}, // R5 m=2
        '{5'd3,  1'b1, 1'b0, 1'b0, 5'd1,  32'h00123456, 4'd0}, // R5 m=3
        '{5'd4,  1'b1, 1'b0, 1'b0, 5'd1,  32'h12345678, 4'd0}, // R5 m=4
        '{5'd1,  1'b1, 1'b0, 1'b0, 5'd1,  32'hFFFFFFF0, 4'd0}, // R5 m=1 neg
        '{5'd3,  1'b1, 1'b0, 1'b0, 5'd1,  32'h80000000, 4'd0}, // R5 m=4 neg
        '{5'd5,  1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd0}, // R7
        '{5'd6,  1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd0}, // R7
        '{5'd12, 1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd0}, // R7
        '{5'd7,  1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd0}, // R8
        '{5'd7,  1'b1, 1'b1, 1'b0, 5'd1,  32'h0,        4'd0}, // R8 pc
        '{5'd8,  1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd0}, // R8
        '{5'd9,  1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd0}, // R8
        '{5'd10, 1'b1, 1'b0, 1'b0, 5'd4,  32'h0,        4'd0}, // R9
        '{5'd10, 1'b1, 1'b1, 1'b0, 5'd3,  32'h0,        4'd0}, // R9 pc
        '{5'd11, 1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd0}, // R9 n=1
        '{5'd10, 1'b1, 1'b0, 1'b0, 5'd0,  32'h0,        4'd0}, // R9 n=0
        '{5'd11, 1'b1, 1'b0, 1'b0, 5'd16, 32'h0,        4'd0}, // R9 n=16
        '{5'd13, 1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd0}, // R10 busy 0
        '{5'd14, 1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd1}, // R10 busy 1
        '{5'd15, 1'b1, 1'b0, 1'b0, 5'd1,  32'h0,        4'd5}, // R10 busy 5
        '{5'd16, 1'b1, 1'b0, 1'b0, 5'd3,  32'h0,        4'd2}, // R10 busy 2
        '{5'd4,  1'b0, 1'b1, 1'b1, 5'd7,  32'h12345678, 4'd0}  // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  instr_class = '0;
    logic        cond_pass = 1'b1;
    logic        pc_dest = 1'b0;
    logic        reg_shift = 1'b0;
    logic [4:0]  word_count = 5'd1;
    logic [31:0] mul_operand = '0;
    logic        cp_busy = 1'b0;
    logic [1:0]  cyc_type;
    logic        cyc_valid;
    logic        cyc_done;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;

    logic [1:0] exp_q[$];
    logic [1:0] act_q[$];

    bus_cycle_sequencer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .instr_class (instr_class),
        .cond_pass   (cond_pass),
        .pc_dest     (pc_dest),
        .reg_shift   (reg_shift),
        .word_count  (word_count),
        .mul_operand (mul_operand),
        .cp_busy     (cp_busy),
        .cyc_type    (cyc_type),
        .cyc_valid   (cyc_valid),
        .cyc_done    (cyc_done)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 50000) begin
                errors++;
                $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 50000", cyc_cnt);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    function automatic int mlen(input logic [31:0] op);
        if (op[31:8] == '0 || op[31:8] == '1) return 1;
        if (op[31:16] == '0 || op[31:16] == '1) return 2;
        if (op[31:24] == '0 || op[31:24] == '1) return 3;
        return 4;
    endfunction

    function automatic string tag_of(input vec_t v);
        if (!v.cond) return "R3";
        case (v.cls)
            5'd0:                      return "R4";
            5'd1, 5'd2, 5'd3, 5'd4:    return "R5,R6";
            5'd5, 5'd6, 5'd12:         return "R7";
            5'd7, 5'd8, 5'd9:          return "R8";
            5'd10, 5'd11:              return "R9";
            default:                   return "R10";
        endcase
    endfunction

    function automatic string seq_str(input logic [1:0] q[$]);
        string s = "";
        foreach (q[i]) begin
            case (q[i])
                TN:      s = {s, "N"};
                TS:      s = {s, "S"};
                TI:      s = {s, "I"};
                default: s = {s, "C"};
            endcase
        end
        return s;
    endfunction

    task automatic push(input logic [1:0] t, input int cnt);
        for (int i = 0; i < cnt; i++) exp_q.push_back(t);
    endtask

    // Reference sequences written from the requirements.
    task automatic build_exp(input vec_t v);
        int m;
        int nm1;
        m   = mlen(v.op);
        nm1 = (v.n == 0) ? 0 : int'(v.n) - 1;
        exp_q.delete();
        if (!v.cond) begin
            push(TS, 1);
        end else begin
            case (v.cls)
                5'd0: begin
                    if (v.sh) push(TI, 1);
                    if (v.pc) begin push(TN, 1); push(TS, 2); end
                    else push(TS, 1);
                end
                5'd1: begin push(TI, m); push(TS, 1); end
                5'd2: begin push(TI, 1 + m); push(TS, 1); end
                5'd3: begin push(TI, m + 1); push(TS, 1); end
                5'd4: begin push(TI, 1 + m + 1); push(TS, 1); end
                5'd5, 5'd6: begin push(TN, 1); push(TS, 2); end
                5'd7: begin
                    push(TN, 1); push(TI, 1);
                    if (v.pc) begin push(TN, 1); push(TS, 2); end
                    else push(TS, 1);
                end
                5'd8: push(TN, 2);
                5'd9: begin push(TN, 2); push(TI, 1); push(TS, 1); end
                5'd10: begin
                    push(TN, 1); push(TS, nm1); push(TI, 1);
                    if (v.pc) begin push(TN, 1); push(TS, 2); end
                    else push(TS, 1);
                end
                5'd11: begin push(TN, 1); push(TS, nm1); push(TI, 1); push(TN, 1); end
                5'd13: begin push(TI, int'(v.busy)); push(TS, 1); end
                5'd14: begin push(TI, int'(v.busy)); push(TC, 1); push(TN, 1); end
                5'd15: begin push(TI, int'(v.busy)); push(TC, 1); push(TI, 1); push(TS, 1); end
                5'd16: begin
                    push(TI, int'(v.busy)); push(TN, 1); push(TS, nm1); push(TN, 1);
                end
                default: push(TS, 1);
            endcase
        end
    endtask

    // Issue one instruction and compare the whole emitted sequence.
    task automatic run_vec(input vec_t v, input bit poke_mid, input bit poke_done, input string tag);
        bit gap;
        bit got_done;
        bit same;
        build_exp(v);
        act_q.delete();
        gap = 0;
        got_done = 0;
        @(negedge clk);
        instr_class = v.cls;
        cond_pass   = v.cond;
        pc_dest     = v.pc;
        reg_shift   = v.sh;
        word_count  = v.n;
        mul_operand = v.op;
        cp_busy     = 1'b0;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 64 && !got_done; c++) begin
            cp_busy = (c < int'(v.busy));
            #1;
            if (cyc_valid !== 1'b1) gap = 1;
            act_q.push_back(cyc_type);
            if (cyc_done === 1'b1) got_done = 1;
            if (poke_mid && c == 1) begin
                start = 1'b1;
                instr_class = 5'd8;
            end
            if (poke_done && got_done) begin
                start = 1'b1;
                instr_class = 5'd9;
            end
            @(negedge clk);
            start = 1'b0;
        end
        cp_busy = 1'b0;
        #1;
        same = (act_q.size() == exp_q.size());
        if (same) foreach (exp_q[i]) if (act_q[i] !== exp_q[i]) same = 0;
        checks++;
        if (gap || !got_done || !same) begin
            errors++;
            $display("FAIL %s sequence: actual %s (gap=%0d done=%0d) expected %s",
                     tag, seq_str(act_q), gap, got_done, seq_str(exp_q));
        end
        checks++;
        if (cyc_valid !== 1'b0 || cyc_done !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle after done (%s): actual valid=%0b done=%0b expected 0 0",
                     tag, cyc_valid, cyc_done);
        end
    endtask

    initial begin
        // R11: outputs low while reset is held.
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (cyc_valid !== 1'b0 || cyc_done !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset state: actual valid=%0b done=%0b expected 0 0", cyc_valid, cyc_done);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: no start, no activity.
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (cyc_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle without start: actual valid=%0b expected 0", cyc_valid);
        end

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 1'b0, 1'b0, tag_of(VECS[i]));
        end

        // R2: start in mid-run and start in the done cycle are both ignored.
        run_vec(VECS[17], 1'b1, 1'b0, "R2 mid-run start");
        run_vec(VECS[7],  1'b0, 1'b1, "R2 start on done");
        run_vec(VECS[24], 1'b1, 1'b1, "R2 busy-wait with starts");

        // R7: unused class code gives a single S.
        run_vec('{5'd25, 1'b1, 1'b0, 1'b0, 5'd1, 32'h0, 4'd0}, 1'b0, 1'b0, "R7 unused code");

        // R11: reset in the middle of a long sequence.
        @(negedge clk);
        instr_class = 5'd10;
        cond_pass   = 1'b1;
        pc_dest     = 1'b0;
        word_count  = 5'd8;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        checks++;
        if (cyc_valid !== 1'b0 || cyc_done !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset mid-run: actual valid=%0b done=%0b expected 0 0", cyc_valid, cyc_done);
        end
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        checks++;
        if (cyc_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 after reset release: actual valid=%0b expected 0", cyc_valid);
        end

        // Sequencer still works after the reset.
        run_vec(VECS[13], 1'b0, 1'b0, "R11 R8 after reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule